// File: doc/BRIEF.md
# Key Combination Reset Generator

This block sits behind a keypad scanner and turns a held combination of keys into a reset pulse. It receives the debounced pressed/released level of every key as a flat vector. Up to three trigger conditions are programmed. Each condition names one key and the level that key must show. When every enabled condition holds at once and keeps holding for a programmed hold time, the block emits one reset pulse. The width and the active level of that pulse are programmable.

Timing is counted in ticks of `TICK_CYCLES` clock cycles. Both the hold window and the pulse window start from the cycle in which their own event begins. After a pulse the block stays locked until the combination is broken, so a held combination yields exactly one reset. A passthrough mode forwards an external reset request to the same output. All configuration arrives as plain input ports.

Top module: `key_combo_reset`

## Requirements
- R1: A condition byte holds the required level in bit 7 (1 = pressed) and the key identifier in bits 6:0. Identifier k in 1..NUM_KEYS refers to `key_lvl[k-1]`. An identifier above NUM_KEYS reads as a released key.
- R2: A condition whose identifier is 0 is disabled and counts as satisfied. When all three identifiers are 0, the block never produces a key-triggered pulse.
- R3: A pulse requires every enabled condition to hold at the same time. If any enabled condition fails before the hold time is reached, timing restarts from the next cycle in which all of them hold.
- R4: If the combination first holds at clock edge e0 and keeps holding, the output turns active right after edge e0 + hold_code*TICK_CYCLES. A hold_code of 0 makes it active right after e0.
- R5: width_code 0, 1, 2 and 3 give an active pulse of 1, 2, 4 and 8 ticks. The pulse runs to its full length even if the keys are released during it.
- R6: With active_high = 1 the active output level is 1, and with active_high = 0 it is 0. The output sits at the opposite level whenever no reset is being driven.
- R7: With pass_en = 1, ext_rst_in = 1 makes the output active one cycle later. With pass_en = 0, ext_rst_in has no effect on the output.
- R8: After a pulse ends, no further pulse occurs while the combination keeps holding. Once the combination fails for at least one cycle, the block arms again.
- R9: While the synchronous reset rst is high, the output takes its inactive level at the next edge and any hold or pulse in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_lvl | input | NUM_KEYS | Key levels from the scanner, 1 = pressed; bit k-1 is key k |
| trig0 | input | 8 | Trigger condition 0: {level, identifier[6:0]} |
| trig1 | input | 8 | Trigger condition 1 |
| trig2 | input | 8 | Trigger condition 2 |
| hold_code | input | 4 | Hold time in ticks |
| width_code | input | 2 | Pulse width select (1, 2, 4, 8 ticks) |
| active_high | input | 1 | Output polarity, 1 = active-high |
| pass_en | input | 1 | Enables forwarding of ext_rst_in |
| ext_rst_in | input | 1 | External reset request, active-high |
| rst_out | output | 1 | Registered reset output |

## Verification
The bench sweeps all 16 hold codes against all four width codes with alternating polarity. A design that miscounts the hold window by one cycle, or that maps width codes linearly, shows up as a wrong first-active cycle or a wrong pulse length. It also sweeps every key pattern against a three-condition combination, and every identifier, including zero and out-of-range ones, against both levels. A wrong key index or a missing AND of the conditions then fires on the wrong patterns. Directed sequences break the combination partway through a hold, which catches a timer that is not restarted. They release the keys in mid-pulse, which catches a pulse that is truncated. They re-press after a pulse, which catches a design that retriggers while held or never re-arms. They also drive the external request with passthrough on and off, and apply reset in mid-pulse.

// File: rtl/kcr_pkg.sv
package kcr_pkg;
  localparam int ID_W   = 7;
  localparam int COND_W = ID_W + 1;
  localparam int N_COND = 3;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_ARM  = 2'd1,
    KS_FIRE = 2'd2,
    KS_LOCK = 2'd3
  } kcr_state_e;

  typedef struct packed {
    logic            lvl;
    logic [ID_W-1:0] id;
  } kcr_cond_t;
endpackage

// File: rtl/kcr_cond_match.sv
module kcr_cond_match
  import kcr_pkg::*;
#(
  parameter int NUM_KEYS = 25
) (
  input  logic [COND_W-1:0]   cond,
  input  logic [NUM_KEYS-1:0] keys,
  output logic                hit,
  output logic                used
);
  kcr_cond_t c;
  logic      sel;

  assign c = kcr_cond_t'(cond);

  // identifiers outside 1..NUM_KEYS read as a released key
  always_comb begin
    sel = 1'b0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (c.id == ID_W'(i + 1)) sel = keys[i];
    end
  end

  assign used = |c.id;
  assign hit  = !used || (sel == c.lvl);
endmodule

// File: rtl/kcr_seq.sv
module kcr_seq
  import kcr_pkg::*;
#(
  parameter int TICK_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       all_hit,
  input  logic [3:0] hold_code,
  input  logic [1:0] width_code,
  output logic       pulse_nxt
);
  localparam int MAX_CYC = 15 * TICK_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

  kcr_state_e       st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [CNT_W-1:0] wlim, wlim_n;
  logic [CNT_W-1:0] hold_lim, wid_cyc;

  assign hold_lim = CNT_W'(hold_code) * CNT_W'(TICK_CYCLES);
  assign wid_cyc  = CNT_W'(TICK_CYCLES) << width_code;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    wlim_n = wlim;
    unique case (st)
      KS_IDLE: begin
        if (all_hit) begin
          cnt_n = CNT_W'(1);
          if (hold_lim == '0) begin
            st_n   = KS_FIRE;
            wlim_n = wid_cyc;
          end else begin
            st_n = KS_ARM;
          end
        end
      end
      KS_ARM: begin
        if (!all_hit) begin
          st_n = KS_IDLE;
        end else if (cnt >= hold_lim) begin
          st_n   = KS_FIRE;
          cnt_n  = CNT_W'(1);
          wlim_n = wid_cyc;
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      KS_FIRE: begin
        if (cnt >= wlim) st_n = KS_LOCK;
        else             cnt_n = cnt + CNT_W'(1);
      end
      KS_LOCK: begin
        if (!all_hit) st_n = KS_IDLE;
      end
      default: st_n = KS_IDLE;
    endcase
  end

  assign pulse_nxt = (st_n == KS_FIRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= KS_IDLE;
      cnt  <= '0;
      wlim <= '0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      wlim <= wlim_n;
    end
  end

  // R3: a broken combination during the hold returns to idle
  p_abort_r3: assert property (@(posedge clk) disable iff (rst)
    (st == KS_ARM && !all_hit) |=> (st == KS_IDLE));

  // R4: a nonzero hold code never fires straight from idle
  p_hold_min_r4: assert property (@(posedge clk) disable iff (rst)
    (st == KS_IDLE && hold_code != 4'd0) |=> (st != KS_FIRE));

  // R5: the pulse counter stays within the latched width
  p_pulse_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (st == KS_FIRE) |-> (cnt != '0 && cnt <= wlim));

  // R8: a held combination keeps the block locked
  p_lock_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (st == KS_LOCK && all_hit) |=> (st == KS_LOCK));
endmodule

// File: rtl/kcr_out_stage.sv
module kcr_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic pulse_nxt,
  input  logic pass_en,
  input  logic ext_rst_in,
  input  logic active_high,
  output logic rst_out
);
  logic act;

  assign act = pulse_nxt || (pass_en && ext_rst_in);

  always_ff @(posedge clk) begin
    if (rst) rst_out <= ~active_high;
    else     rst_out <= active_high ? act : ~act;
  end

  // R7: an enabled external request reaches the active level next cycle
  p_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (pass_en && ext_rst_in) |=> (rst_out == $past(active_high)));

  // R6: with no request the output rests at the inactive level
  p_idle_level_r6: assert property (@(posedge clk) disable iff (rst)
    (!pulse_nxt && !(pass_en && ext_rst_in)) |=> (rst_out != $past(active_high)));
endmodule

// File: rtl/key_combo_reset.sv
module key_combo_reset
  import kcr_pkg::*;
#(
  parameter int NUM_KEYS    = 25,
  parameter int TICK_CYCLES = 1000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] key_lvl,
  input  logic [7:0]          trig0,
  input  logic [7:0]          trig1,
  input  logic [7:0]          trig2,
  input  logic [3:0]          hold_code,
  input  logic [1:0]          width_code,
  input  logic                active_high,
  input  logic                pass_en,
  input  logic                ext_rst_in,
  output logic                rst_out
);
  logic [N_COND-1:0][COND_W-1:0] trig_vec;
  logic [N_COND-1:0]             hit, used;
  logic                          all_hit;
  logic                          pulse_nxt;

  assign trig_vec[0] = trig0;
  assign trig_vec[1] = trig1;
  assign trig_vec[2] = trig2;

  for (genvar g = 0; g < N_COND; g++) begin : g_cond
    kcr_cond_match #(.NUM_KEYS(NUM_KEYS)) u_cm (
      .cond (trig_vec[g]),
      .keys (key_lvl),
      .hit  (hit[g]),
      .used (used[g])
    );
  end

  // at least one enabled condition, and all of them satisfied
  assign all_hit = (&hit) && (|used);

  kcr_seq #(.TICK_CYCLES(TICK_CYCLES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .all_hit    (all_hit),
    .hold_code  (hold_code),
    .width_code (width_code),
    .pulse_nxt  (pulse_nxt)
  );

  kcr_out_stage u_out (
    .clk         (clk),
    .rst         (rst),
    .pulse_nxt   (pulse_nxt),
    .pass_en     (pass_en),
    .ext_rst_in  (ext_rst_in),
    .active_high (active_high),
    .rst_out     (rst_out)
  );
endmodule

// File: tb/sim_key_combo_reset.sv
module sim_key_combo_reset;
  localparam int NK = 6;
  localparam int TC = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NK-1:0] key_lvl = '0;
  logic [7:0]    trig0 = '0, trig1 = '0, trig2 = '0;
  logic [3:0]    hold_code = '0;
  logic [1:0]    width_code = '0;
  logic          pol = 1'b1;
  logic          pass_en = 1'b0;
  logic          ext_rst_in = 1'b0;
  logic          rst_out;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  key_combo_reset #(.NUM_KEYS(NK), .TICK_CYCLES(TC)) u0 (
    .clk(clk), .rst(rst), .key_lvl(key_lvl),
    .trig0(trig0), .trig1(trig1), .trig2(trig2),
    .hold_code(hold_code), .width_code(width_code),
    .active_high(pol), .pass_en(pass_en), .ext_rst_in(ext_rst_in),
    .rst_out(rst_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic observe(input int win, output int first, output int len, output int pulses);
    bit prev = 1'b0;
    bit a;
    first = -1; len = 0; pulses = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      a = (rst_out == pol);
      if (a && !prev) pulses++;
      if (a && first < 0) first = k;
      if (a && pulses == 1) len++;
      prev = a;
    end
  endtask

  task automatic run_case(input string req, input bit exp_fire, input int exp_h, input int exp_w);
    int first, len, pulses;
    restart();
    observe(100, first, len, pulses);
    if (exp_fire) begin
      chk(first == exp_h, {req, " delay"}, first, exp_h);
      chk(len == exp_w, {req, " width"}, len, exp_w);
      chk(pulses == 1, "R8 single pulse while held", pulses, 1);
    end else begin
      chk(pulses == 0, {req, " no pulse"}, pulses, 0);
    end
  endtask

  initial begin
    #1ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int first, len, pulses, cnt;
    bit exp, bitv;

    // R9: reset state, both polarities
    repeat (3) @(negedge clk);
    chk(rst_out == 1'b0, "R9 reset level pol1", rst_out, 0);
    pol = 1'b0;
    @(negedge clk);
    chk(rst_out == 1'b1, "R9 reset level pol0", rst_out, 1);
    pol = 1'b1;
    rst = 1'b0;

    // R4, R5, R6: every hold code against every width code
    trig0 = {1'b1, 7'd2}; trig1 = '0; trig2 = '0; key_lvl = 6'b000010;
    for (int h = 0; h < 16; h++) begin
      for (int w = 0; w < 4; w++) begin
        hold_code = 4'(h); width_code = 2'(w); pol = 1'((h + w) % 2);
        run_case("R4 R5 R6 hold/width", 1'b1, h * TC, (1 << w) * TC);
      end
    end

    // R1, R2: identifiers 0..NK+1 against both levels and several key patterns
    hold_code = 4'd0; width_code = 2'd0; pol = 1'b1;
    for (int id = 0; id <= NK + 1; id++) begin
      for (int lv = 0; lv < 2; lv++) begin
        for (int p = 0; p < 4; p++) begin
          case (p)
            0: key_lvl = 6'b000000;
            1: key_lvl = 6'b101010;
            2: key_lvl = 6'b010101;
            default: key_lvl = 6'b111111;
          endcase
          trig0 = {1'(lv), 7'(id)};
          bitv = (id >= 1 && id <= NK) ? key_lvl[id - 1] : 1'b0;
          exp = (id != 0) && (1'(lv) == bitv);
          run_case(id == 0 ? "R2 all disabled" : "R1 key map", exp, 0, TC);
        end
      end
    end

    // R3: key1 pressed, key3 released, key5 pressed, over all key patterns
    trig0 = {1'b1, 7'd1}; trig1 = {1'b0, 7'd3}; trig2 = {1'b1, 7'd5};
    hold_code = 4'd1; width_code = 2'd0;
    for (int pt = 0; pt < 64; pt++) begin
      key_lvl = 6'(pt);
      exp = key_lvl[0] && !key_lvl[2] && key_lvl[4];
      run_case("R3 combination", exp, TC, TC);
    end

    // R3: breaking the combination mid-hold restarts timing
    trig0 = {1'b1, 7'd1}; trig1 = '0; trig2 = '0; key_lvl = 6'b000001;
    hold_code = 4'd4; width_code = 2'd0;
    restart();
    cnt = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (rst_out == pol) cnt++;
    end
    key_lvl = 6'b000000;
    repeat (2) @(negedge clk);
    if (rst_out == pol) cnt++;
    chk(cnt == 0, "R3 no pulse during aborted hold", cnt, 0);
    key_lvl = 6'b000001;
    observe(60, first, len, pulses);
    chk(first == 4 * TC, "R3 restart delay", first, 4 * TC);

    // R5: full pulse even when released in mid-pulse
    hold_code = 4'd0; width_code = 2'd3;
    restart();
    @(negedge clk);
    chk(rst_out == pol, "R5 pulse start", rst_out, pol);
    key_lvl = 6'b000000;
    cnt = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (rst_out == pol) cnt++;
    end
    chk(cnt == 8 * TC, "R5 width after release", cnt, 8 * TC);

    // R8: re-arm after a one-cycle release
    key_lvl = 6'b000001; hold_code = 4'd2; width_code = 2'd1;
    restart();
    observe(30, first, len, pulses);
    chk(pulses == 1, "R8 first pulse", pulses, 1);
    key_lvl = 6'b000000;
    @(negedge clk);
    key_lvl = 6'b000001;
    observe(40, first, len, pulses);
    chk(first == 2 * TC, "R8 re-arm delay", first, 2 * TC);
    chk(len == 2 * TC, "R8 re-arm width", len, 2 * TC);

    // R9: reset in mid-pulse
    hold_code = 4'd0; width_code = 2'd3;
    restart();
    repeat (3) @(negedge clk);
    chk(rst_out == pol, "R9 pulse running", rst_out, pol);
    rst = 1'b1;
    @(negedge clk);
    chk(rst_out != pol, "R9 reset cuts pulse", rst_out, !pol);
    rst = 1'b0;

    // R7: passthrough on and off, active-low output
    trig0 = '0; pol = 1'b0; pass_en = 1'b1;
    restart();
    @(negedge clk);
    chk(rst_out == 1'b1, "R7 idle before request", rst_out, 1);
    ext_rst_in = 1'b1;
    @(negedge clk);
    chk(rst_out == 1'b0, "R7 forwarded request", rst_out, 0);
    ext_rst_in = 1'b0;
    @(negedge clk);
    chk(rst_out == 1'b1, "R7 request removed", rst_out, 1);
    pass_en = 1'b0; ext_rst_in = 1'b1;
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (rst_out == 1'b0) cnt++;
    end
    chk(cnt == 0, "R7 ignored when disabled", cnt, 0);
    ext_rst_in = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule